// File: doc/BRIEF.md
# Clock Controller Register Bank

This block is the software-visible configuration store of a clock controller. A simple 32-bit register bus gives it an address, separate read and write strobes and write data. It returns registered read data and a one-cycle rejection flag. The bank holds the control words of thirteen PLLs, the bus divider settings, the peripheral clock settings and the DRAM clock settings. It generates no clocks itself: it stores words, changes a few flag bits as they are written, and returns them on a read.

Three write rules change a word before it is stored:
- Enabling a PLL makes its lock flag read back as set at once, so boot software that polls for lock never waits.
- Two update-request bits (the DDR1 PLL update and the DRAM clock update) are self-clearing and always read back as zero.
- Accesses outside the implemented 201-word range, and accesses to unaligned addresses, are refused and flagged.

Top module: `clkctl_regbank`

## Requirements
- R1: Addresses are byte offsets into a 1 KiB window. An aligned address (low two bits 0) below 0x324 selects the 32-bit word at index address/4.
- R2: After reset, offsets 0x010, 0x018, 0x030, 0x038 and 0x048 read 0x03006207. Offsets 0x000 and 0x020 read 0x00001000. Offsets 0x028 and 0x02C read 0x00041811. The remaining non-zero reset values are 0x008=0x00035514, 0x034=0x00001811, 0x040=0x00000515, 0x04C=0x00001800, 0x054=0x00001010, 0x058=0x01000000, 0x0F0=0x00000001, 0x0F8=0x0CCCA000 and 0x310=0x0000000F. Every other word reads 0.
- R3: The PLL words are at offsets 0x000, 0x008, 0x010, 0x018, 0x020, 0x028, 0x02C, 0x030, 0x034, 0x038, 0x040, 0x048 and 0x04C. A write to any of them with bit 31 (enable) at 1 stores bit 28 (lock) as 1.
- R4: A write to a PLL word with bit 31 at 0 stores bit 28 exactly as written.
- R5: A write to offset 0x04C stores bit 30 as 0, and then R3/R4 apply.
- R6: A write to offset 0x0F4 stores bit 16 as 0. All other bits of that word are stored as written.
- R7: Writes to every other in-range offset are stored unchanged. This includes unnamed words and the last word at 0x320. Bit 31 of a non-PLL word never sets bit 28.
- R8: An access is out of range when the address is 0x324 or above, or when it is not a multiple of 4. An out-of-range read returns 0. An out-of-range write changes no stored word.
- R9: `err` is 1 in the cycle after an out-of-range access and 0 in the cycle after an in-range access or an idle cycle.
- R10: Read data appears on `rdata` in the cycle after the `rd` strobe and holds until the next read.
- R11: When `rd` and `wr` target the same word in one cycle, the read returns the word's contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | 10 | Byte address of the access |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle flag for an out-of-range access |

## Verification
The hardest case to reach from the ports is a read and a write to the same word in the same cycle. In that case the registered read must return the old contents while the array takes the new ones. The bench drives both strobes in one cycle, checks `rdata` against the old value, and then reads again to see the new one. The second hard case is an unaligned write whose word index falls on a live register. The bench writes to 0x056 and then reads 0x054 to prove that the stored word did not move.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 10;
  localparam int unsigned NUM_WORDS = 201;

  // Flag positions inside the words
  localparam int unsigned PLL_EN_BIT   = 31;
  localparam int unsigned PLL_LOCK_BIT = 28;
  localparam int unsigned DDR1_UPD_BIT = 30;
  localparam int unsigned DRAM_UPD_BIT = 16;

  // Word indices with special write handling
  localparam int unsigned DDR1_IDX     = 19;
  localparam int unsigned DRAM_CFG_IDX = 61;

  function automatic logic is_pll_idx(input int unsigned idx);
    case (idx)
      0, 2, 4, 6, 8, 10, 11, 12, 13, 14, 16, 18, 19: return 1'b1;
      default:                                      return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reset_word(input int unsigned idx);
    case (idx)
      0, 8:               return 32'h0000_1000;
      2:                  return 32'h0003_5514;
      4, 6, 12, 14, 18:   return 32'h0300_6207;
      10, 11:             return 32'h0004_1811;
      13:                 return 32'h0000_1811;
      16:                 return 32'h0000_0515;
      19:                 return 32'h0000_1800;
      21:                 return 32'h0000_1010;
      22:                 return 32'h0100_0000;
      60:                 return 32'h0000_0001;
      62:                 return 32'h0CCC_A000;
      196:                return 32'h0000_000F;
      default:            return '0;
    endcase
  endfunction

endpackage

// File: rtl/clkctl_addr_dec.sv
module clkctl_addr_dec
  import clkctl_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned WORDS = NUM_WORDS,
  localparam int unsigned IW   = AW - 2
) (
  input  logic [AW-1:0] addr,
  output logic [IW-1:0] idx,
  output logic          in_range,
  output logic          is_pll,
  output logic          is_ddr1,
  output logic          is_dram
);

  always_comb begin
    idx      = addr[AW-1:2];
    in_range = (addr[1:0] == 2'b00) && (int'(idx) < int'(WORDS));
    is_pll   = in_range && is_pll_idx(int'(idx));
    is_ddr1  = in_range && (int'(idx) == int'(DDR1_IDX));
    is_dram  = in_range && (int'(idx) == int'(DRAM_CFG_IDX));
  end

endmodule

// File: rtl/clkctl_wr_xform.sv
module clkctl_wr_xform
  import clkctl_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [DW-1:0] wdata,
  input  logic          is_pll,
  input  logic          is_ddr1,
  input  logic          is_dram,
  output logic [DW-1:0] wdata_x
);

  always_comb begin
    wdata_x = wdata;
    // self-clearing update requests
    if (is_ddr1) wdata_x[DDR1_UPD_BIT] = 1'b0;
    if (is_dram) wdata_x[DRAM_UPD_BIT] = 1'b0;
    // an enabled PLL reports lock immediately
    if (is_pll && wdata_x[PLL_EN_BIT]) wdata_x[PLL_LOCK_BIT] = 1'b1;
  end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned WORDS = NUM_WORDS,
  localparam int unsigned IW   = AW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err
);

  logic [IW-1:0] dec_idx;
  logic          dec_ok, dec_pll, dec_ddr1, dec_dram;
  logic [DW-1:0] wdata_x;

  clkctl_addr_dec #(.AW(AW), .WORDS(WORDS)) u_dec (
    .addr     (addr),
    .idx      (dec_idx),
    .in_range (dec_ok),
    .is_pll   (dec_pll),
    .is_ddr1  (dec_ddr1),
    .is_dram  (dec_dram)
  );

  clkctl_wr_xform #(.DW(DW)) u_xf (
    .wdata   (wdata),
    .is_pll  (dec_pll),
    .is_ddr1 (dec_ddr1),
    .is_dram (dec_dram),
    .wdata_x (wdata_x)
  );

  // Storage: one register per word, reset value from the package
  logic             wr_ok;
  logic [DW-1:0]    word_q [WORDS];

  assign wr_ok = wr && dec_ok;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic          we;
    logic [DW-1:0] q;

    assign we = wr_ok && (int'(dec_idx) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= reset_word(g);
      else if (we) q <= wdata_x;
    end

    assign word_q[g] = q;
  end

  // Read path and rejection flag: next-state
  logic [DW-1:0] rdata_d;
  logic          err_d;

  always_comb begin
    rdata_d = '0;
    if (dec_ok) rdata_d = word_q[dec_idx];
    err_d = (rd || wr) && !dec_ok;
  end

  // Read path and rejection flag: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      if (rd) rdata <= rdata_d;
      err <= err_d;
    end
  end

  // Checks on the stored words and the bus outputs

  p_lock_on_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dec_pll && wdata[PLL_EN_BIT]) |=> word_q[$past(dec_idx)][PLL_LOCK_BIT])
    else $error("lock flag not set after enabling write");

  p_lock_as_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dec_pll && !wdata[PLL_EN_BIT])
      |=> (word_q[$past(dec_idx)][PLL_LOCK_BIT] == $past(wdata[PLL_LOCK_BIT])))
    else $error("lock flag altered while disabled");

  p_ddr1_upd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dec_ddr1) |=> !word_q[DDR1_IDX][DDR1_UPD_BIT])
    else $error("DDR1 update bit stored");

  p_dram_upd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dec_dram) |=> !word_q[DRAM_CFG_IDX][DRAM_UPD_BIT])
    else $error("DRAM update bit stored");

  p_plain_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dec_ok && !dec_pll && !dec_dram) |=> (word_q[$past(dec_idx)] == $past(wdata)))
    else $error("plain word not stored as written");

  p_oob_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !dec_ok) |=> (rdata == '0))
    else $error("out-of-range read returned data");

  p_err_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err == $past((rd || wr) && !dec_ok)))
    else $error("error flag mismatch");

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata))
    else $error("read data moved without a read");

endmodule

// File: tb/sim_clkctl_regbank.sv
module sim_clkctl_regbank;

  logic        clk;
  logic        rst_n;
  logic [9:0]  addr;
  logic        wr;
  logic        rd;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        err;

  int n_chk;
  int n_fail;
  bit done;

  clkctl_regbank u0 (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wr    (wr),
    .rd    (rd),
    .wdata (wdata),
    .rdata (rdata),
    .err   (err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_reset(input int off);
    case (off)
      'h010, 'h018, 'h030, 'h038, 'h048: return 32'h0300_6207;
      'h000, 'h020:                      return 32'h0000_1000;
      'h028, 'h02C:                      return 32'h0004_1811;
      'h008: return 32'h0003_5514;
      'h034: return 32'h0000_1811;
      'h040: return 32'h0000_0515;
      'h04C: return 32'h0000_1800;
      'h054: return 32'h0000_1010;
      'h058: return 32'h0100_0000;
      'h0F0: return 32'h0000_0001;
      'h0F8: return 32'h0CCC_A000;
      'h310: return 32'h0000_000F;
      default: return 32'h0;
    endcase
  endfunction

  // one access: drive at a falling edge, sample at the next falling edge
  task automatic bus_op(input logic [9:0] a, input logic w, input logic r,
                        input logic [31:0] d, output logic [31:0] q, output logic e);
    @(negedge clk);
    addr = a; wr = w; rd = r; wdata = d;
    @(negedge clk);
    q = rdata; e = err;
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic do_wr(input logic [9:0] a, input logic [31:0] d, output logic e);
    logic [31:0] q;
    bus_op(a, 1'b1, 1'b0, d, q, e);
  endtask

  task automatic do_rd(input logic [9:0] a, output logic [31:0] q, output logic e);
    bus_op(a, 1'b0, 1'b1, 32'h0, q, e);
  endtask

  task automatic t_reset;
    logic [31:0] q; logic e;
    chk("R9 err after reset", {31'b0, err}, 32'h0);
    chk("R10 rdata after reset", rdata, 32'h0);
    for (int i = 0; i < 201; i++) begin
      do_rd(10'(i*4), q, e);
      chk("R2 reset value", q, exp_reset(i*4));
    end
  endtask

  task automatic t_pll_lock;
    int offs [13] = '{'h000, 'h008, 'h010, 'h018, 'h020, 'h028, 'h02C,
                      'h030, 'h034, 'h038, 'h040, 'h048, 'h04C};
    logic [31:0] q; logic e;
    for (int i = 0; i < 13; i++) begin
      do_wr(10'(offs[i]), 32'h8000_1234 + 32'(i), e);
      chk("R1 in-range write err", {31'b0, e}, 32'h0);
      do_rd(10'(offs[i]), q, e);
      chk("R3 lock set on enable", q, 32'h9000_1234 + 32'(i));
    end
    do_wr(10'h028, 32'h0ABC_DE00, e);
    do_rd(10'h028, q, e);
    chk("R4 lock stays clear when disabled", q, 32'h0ABC_DE00);
    do_wr(10'h040, 32'h1000_0055, e);
    do_rd(10'h040, q, e);
    chk("R4 lock kept when disabled", q, 32'h1000_0055);
  endtask

  task automatic t_ddr1;
    logic [31:0] q; logic e;
    do_wr(10'h04C, 32'hFFFF_FFFF, e);
    do_rd(10'h04C, q, e);
    chk("R5 DDR1 update bit cleared", q, 32'hBFFF_FFFF);
    do_wr(10'h04C, 32'h4000_0000, e);
    do_rd(10'h04C, q, e);
    chk("R5 DDR1 update only", q, 32'h0);
    do_wr(10'h04C, 32'hC000_0000, e);
    do_rd(10'h04C, q, e);
    chk("R5 DDR1 update cleared, lock set", q, 32'h9000_0000);
  endtask

  task automatic t_dram;
    logic [31:0] q; logic e;
    do_wr(10'h0F4, 32'hFFFF_FFFF, e);
    do_rd(10'h0F4, q, e);
    chk("R6 DRAM update bit cleared", q, 32'hFFFE_FFFF);
    do_wr(10'h0F4, 32'h0001_0001, e);
    do_rd(10'h0F4, q, e);
    chk("R6 DRAM other bits kept", q, 32'h0000_0001);
  endtask

  task automatic t_plain;
    logic [31:0] q; logic e;
    do_wr(10'h054, 32'hDEAD_BEEF, e);
    do_rd(10'h054, q, e);
    chk("R7 bus config stored", q, 32'hDEAD_BEEF);
    do_wr(10'h320, 32'h5A5A_A5A5, e);
    do_rd(10'h320, q, e);
    chk("R7 last word stored", q, 32'h5A5A_A5A5);
    chk("R1 last word err", {31'b0, e}, 32'h0);
    do_wr(10'h004, 32'h8000_0000, e);
    do_rd(10'h004, q, e);
    chk("R7 non-PLL enable gives no lock", q, 32'h8000_0000);
    do_wr(10'h100, 32'h0001_0000, e);
    do_rd(10'h100, q, e);
    chk("R7 bit 16 kept outside DRAM config", q, 32'h0001_0000);
  endtask

  task automatic t_oob;
    logic [31:0] q; logic e;
    do_rd(10'h324, q, e);
    chk("R8 first out-of-range read", q, 32'h0);
    chk("R9 err on out-of-range read", {31'b0, e}, 32'h1);
    @(negedge clk);
    chk("R9 err lasts one cycle", {31'b0, err}, 32'h0);
    do_wr(10'h3FC, 32'h1234_5678, e);
    chk("R9 err on out-of-range write", {31'b0, e}, 32'h1);
    do_rd(10'h3FC, q, e);
    chk("R8 out-of-range write not stored", q, 32'h0);
    do_wr(10'h056, 32'hFFFF_FFFF, e);
    chk("R9 err on unaligned write", {31'b0, e}, 32'h1);
    do_rd(10'h054, q, e);
    chk("R8 unaligned write changes nothing", q, 32'hDEAD_BEEF);
    do_rd(10'h002, q, e);
    chk("R8 unaligned read returns 0", q, 32'h0);
    chk("R9 err on unaligned read", {31'b0, e}, 32'h1);
  endtask

  task automatic t_same_cycle;
    logic [31:0] q; logic e;
    do_wr(10'h164, 32'hAAAA_0001, e);
    bus_op(10'h164, 1'b1, 1'b1, 32'h5555_0002, q, e);
    chk("R11 read returns old word", q, 32'hAAAA_0001);
    do_rd(10'h164, q, e);
    chk("R11 new word stored", q, 32'h5555_0002);
  endtask

  task automatic t_hold;
    logic [31:0] q; logic e;
    do_rd(10'h0F8, q, e);
    chk("R10 read data one cycle after strobe", q, 32'h0CCC_A000);
    do_wr(10'h0CC, 32'h0000_00FF, e);
    repeat (3) @(negedge clk);
    chk("R10 read data held", rdata, 32'h0CCC_A000);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_pll_lock;
    t_ddr1;
    t_dram;
    t_plain;
    t_oob;
    t_same_cycle;
    t_hold;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule